// File: doc/BRIEF.md
# Pipelined Segmented Match-Line CAM

This block is a binary content-addressable memory. Its wide compare word is cut into equal slices, and each slice is evaluated in its own pipeline stage. A search key enters the first stage, where segment 0 of every valid entry is compared. Each following stage compares its own slice of the key, but only for the entries that matched in every earlier slice. A per-entry survivor vector travels in flip-flops from stage to stage. An entry that failed once has its later segment compares switched off. This saves compare activity on the many entries that fail early. Search latency grows by one register per segment.

After the last stage the block presents:
- the per-entry match vector;
- a hit flag;
- the lowest matching index;
- for every stage, the number of entry segments that stage actually compared for this key.

Tests use the per-stage counts to confirm that an aborted entry costs no further compares. The default shape is a 144-bit word in four 36-bit segments. Setting `SEG_W` to 1 gives one stage per bit. Setting `SEG_W` to half the word gives a two-part pre-search/main-search split.

Entries are loaded through a write port. A small controller with three states arbitrates between writes and searches:
- **IDLE**: searches are accepted.
- **DRAIN**: a write is waiting for the keys already in flight to leave the pipeline; no search is accepted.
- **COMMIT**: the entry is written and the write is acknowledged.

The transitions are:
- IDLE goes to DRAIN on a write request while keys are in flight.
- IDLE goes to COMMIT on a write request with the pipeline empty.
- DRAIN goes to COMMIT once the pipeline is empty.
- COMMIT always returns to IDLE.

As a result, a key never sees a half-updated table.

Top module: `seg_cam`

## Requirements
- R1: After reset `res_valid`, `res_hit` and `wr_ready` are 0, `search_ready` is 1, and every entry is invalid, so no search hits until an entry is written.
- R2: `res_match[e]` is 1 exactly when entry e is valid and all `KEY_W` of its stored bits equal the key.
- R3: `res_hit` is 1 when any match bit is set. `res_idx` is then the lowest set index, and is 0 when there is no hit.
- R4: Segment s covers key bits `[s*SEG_W +: SEG_W]`, and segment 0 is the lowest bits. The `CW`-bit field s of `res_act`, at bits `[s*CW +: CW]`, equals the number of valid entries whose segments 0 to s-1 all matched the key. Field 0 therefore equals the number of valid entries.
- R5: A key can be accepted on every clock. Results leave in acceptance order, one per accepted key.
- R6: A write holds `wr_valid`, `wr_idx` and `wr_data` until `wr_ready` is seen. `wr_ready` is a one-cycle pulse, and on that cycle's closing edge the entry is stored and marked valid.
- R7: While `wr_valid` is high, `search_ready` is low. `wr_ready` is not raised while any accepted key has yet to deliver its result.
- R8: A key accepted on rising edge k gives `res_valid` = 1 with its result in the cycle after edge k+NSEG-1, where NSEG = KEY_W/SEG_W. In every cycle without a result, `res_valid` and `res_match` are 0.
- R9: An invalid entry is never compared and never matches, even when its stored bits equal the key.
- R10: Writing an already valid entry replaces its whole content. Keys accepted before that write see the old content, and keys accepted after it see the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| search_valid | input | 1 | Search key offered |
| search_key | input | KEY_W | Key to look up |
| search_ready | output | 1 | Key is taken on this edge when valid |
| wr_valid | input | 1 | Write request, held until acknowledged |
| wr_idx | input | IDXW | Entry to write |
| wr_data | input | KEY_W | Word to store |
| wr_ready | output | 1 | One-cycle write acknowledge |
| res_valid | output | 1 | Result present this cycle |
| res_match | output | ENTRIES | Per-entry full-word match |
| res_hit | output | 1 | Any entry matched |
| res_idx | output | IDXW | Lowest matching entry |
| res_act | output | NSEG*CW | Per-stage count of enabled segment compares |

## Verification
The bound checker watches several rules on every clock:
- searches stay blocked while a write is pending;
- the write acknowledge lasts one cycle;
- the priority encoder reports the lowest set match bit;
- outputs are quiet between results;
- per-stage activity never rises from one stage to the next, and the final stage count is at least the number of matches.

The exact figures need the bench's reference table. This covers the activity counts for each stage, the pipeline latency, and result ordering under back-to-back keys. It also covers the rule that keys already in flight see the table as it was before a write. The bench's model predicts these per cycle.

// File: rtl/seg_cam_pkg.sv
package seg_cam_pkg;

    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_DRAIN  = 2'd1,
        WR_COMMIT = 2'd2
    } wr_state_e;

endpackage

// File: rtl/seg_cam_store.sv
// Entry storage: word plus valid flag per entry, written only on commit.
module seg_cam_store #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 144,
    parameter int IDXW    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDXW-1:0]          widx,
    input  logic [KEY_W-1:0]         wdata,
    output logic [ENTRIES*KEY_W-1:0] mem_flat,
    output logic [ENTRIES-1:0]       valid_vec
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_flat[e*KEY_W +: KEY_W] <= '0;
                valid_vec[e]               <= 1'b0;
            end else if (we && (widx == IDXW'(e))) begin
                mem_flat[e*KEY_W +: KEY_W] <= wdata;
                valid_vec[e]               <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/seg_cam_wr_fsm.sv
// Write/search arbitration: a write waits for the pipeline to empty.
module seg_cam_wr_fsm
    import seg_cam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic pipe_busy,
    output logic search_ready,
    output logic wr_ready,
    output logic commit
);

    wr_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WR_IDLE:   if (wr_valid) state_nx = pipe_busy ? WR_DRAIN : WR_COMMIT;
            WR_DRAIN:  if (!pipe_busy) state_nx = WR_COMMIT;
            WR_COMMIT: state_nx = WR_IDLE;
            default:   state_nx = WR_IDLE;
        endcase
    end

    always_comb begin
        search_ready = (state == WR_IDLE) && !wr_valid;
        wr_ready     = (state == WR_COMMIT);
        commit       = (state == WR_COMMIT);
    end

endmodule

// File: rtl/seg_cam_stage.sv
// One pipeline stage: compares segment SEG_IDX for surviving entries only.
module seg_cam_stage #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 144,
    parameter int SEG_W   = 36,
    parameter int NSEG    = 4,
    parameter int CW      = 4,
    parameter int SEG_IDX = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [KEY_W-1:0]         in_key,
    input  logic [ENTRIES-1:0]       in_surv,
    input  logic [NSEG*CW-1:0]       in_act,
    input  logic [ENTRIES*SEG_W-1:0] seg_data,
    output logic                     out_valid,
    output logic [KEY_W-1:0]         out_key,
    output logic [ENTRIES-1:0]       out_surv,
    output logic [NSEG*CW-1:0]       out_act
);

    localparam int LO = SEG_IDX * SEG_W;

    logic [SEG_W-1:0]   key_seg;
    logic [ENTRIES-1:0] en;
    logic [ENTRIES-1:0] hit;
    logic [CW-1:0]      cnt;
    logic [NSEG*CW-1:0] act_nx;

    always_comb begin
        key_seg = in_key[LO +: SEG_W];
        en      = in_valid ? in_surv : '0;
        cnt     = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            // comparator of an entry is enabled only when it survived so far
            hit[e] = en[e] && (seg_data[e*SEG_W +: SEG_W] == key_seg);
            cnt    = cnt + CW'(en[e]);
        end
        act_nx = in_act;
        act_nx[SEG_IDX*CW +: CW] = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_key   <= '0;
            out_surv  <= '0;
            out_act   <= '0;
        end else begin
            out_valid <= in_valid;
            out_key   <= in_key;
            out_surv  <= in_valid ? hit : '0;
            out_act   <= in_valid ? act_nx : '0;
        end
    end

endmodule

// File: rtl/seg_cam_prio.sv
// Lowest-index priority encoder.
module seg_cam_prio #(
    parameter int ENTRIES = 8,
    parameter int IDXW    = 3
) (
    input  logic [ENTRIES-1:0] vec,
    output logic               hit,
    output logic [IDXW-1:0]    idx
);

    always_comb begin
        hit = |vec;
        idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (vec[e]) idx = IDXW'(e);
        end
    end

endmodule

// File: rtl/seg_cam.sv
module seg_cam #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 144,
    parameter int SEG_W   = 36,
    localparam int NSEG   = KEY_W / SEG_W,
    localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CW     = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               search_valid,
    input  logic [KEY_W-1:0]   search_key,
    output logic               search_ready,
    input  logic               wr_valid,
    input  logic [IDXW-1:0]    wr_idx,
    input  logic [KEY_W-1:0]   wr_data,
    output logic               wr_ready,
    output logic               res_valid,
    output logic [ENTRIES-1:0] res_match,
    output logic               res_hit,
    output logic [IDXW-1:0]    res_idx,
    output logic [NSEG*CW-1:0] res_act
);

    logic [ENTRIES*KEY_W-1:0] mem_flat;
    logic [ENTRIES-1:0]       valid_vec;
    logic                     commit;
    logic                     pipe_busy;

    logic [NSEG:0]            pv;
    logic [KEY_W-1:0]         pkey  [NSEG+1];
    logic [ENTRIES-1:0]       psurv [NSEG+1];
    logic [NSEG*CW-1:0]       pact  [NSEG+1];
    logic [ENTRIES*SEG_W-1:0] seg_data [NSEG];

    seg_cam_store #(
        .ENTRIES(ENTRIES), .KEY_W(KEY_W), .IDXW(IDXW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we(commit), .widx(wr_idx),
        .wdata(wr_data), .mem_flat(mem_flat), .valid_vec(valid_vec)
    );

    seg_cam_wr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .pipe_busy(pipe_busy),
        .search_ready(search_ready), .wr_ready(wr_ready), .commit(commit)
    );

    // stage-0 inputs: accepted key, valid entries as initial survivors
    assign pv[0]    = search_valid && search_ready;
    assign pkey[0]  = search_key;
    assign psurv[0] = valid_vec;
    assign pact[0]  = '0;
    assign pipe_busy = |pv[NSEG:1];

    for (genvar s = 0; s < NSEG; s++) begin : g_stage
        for (genvar e = 0; e < ENTRIES; e++) begin : g_slice
            assign seg_data[s][e*SEG_W +: SEG_W] = mem_flat[e*KEY_W + s*SEG_W +: SEG_W];
        end

        seg_cam_stage #(
            .ENTRIES(ENTRIES), .KEY_W(KEY_W), .SEG_W(SEG_W),
            .NSEG(NSEG), .CW(CW), .SEG_IDX(s)
        ) u_stage (
            .clk(clk), .rst_n(rst_n),
            .in_valid(pv[s]), .in_key(pkey[s]), .in_surv(psurv[s]),
            .in_act(pact[s]), .seg_data(seg_data[s]),
            .out_valid(pv[s+1]), .out_key(pkey[s+1]),
            .out_surv(psurv[s+1]), .out_act(pact[s+1])
        );
    end

    seg_cam_prio #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_prio (
        .vec(psurv[NSEG]), .hit(res_hit), .idx(res_idx)
    );

    assign res_valid = pv[NSEG];
    assign res_match = psurv[NSEG];
    assign res_act   = pact[NSEG];

endmodule

// File: rtl/seg_cam_chk.sv
module seg_cam_chk #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 144,
    parameter int SEG_W   = 36,
    localparam int NSEG   = KEY_W / SEG_W,
    localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CW     = $clog2(ENTRIES + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               search_ready,
    input logic               wr_valid,
    input logic               wr_ready,
    input logic               res_valid,
    input logic [ENTRIES-1:0] res_match,
    input logic               res_hit,
    input logic [IDXW-1:0]    res_idx,
    input logic [NSEG*CW-1:0] res_act
);

    a_r7_write_blocks_search: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !search_ready);

    a_r7_no_ack_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !wr_ready);

    a_r6_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |=> !wr_ready);

    a_r3_lowest_index: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_match[res_idx] &&
                     ((res_match & ~({ENTRIES{1'b1}} << res_idx)) == '0)));

    a_r3_hit_any: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit == (res_match != '0)));

    a_r8_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_match == '0 && !res_hit));

    a_r4_final_covers_matches: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones(res_match) <= int'(res_act[(NSEG-1)*CW +: CW])));

    for (genvar s = 1; s < NSEG; s++) begin : g_mono
        a_r4_act_monotone: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid |-> (res_act[s*CW +: CW] <= res_act[(s-1)*CW +: CW]));
    end

endmodule

bind seg_cam seg_cam_chk #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .SEG_W(SEG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .search_ready(search_ready), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .res_valid(res_valid), .res_match(res_match),
    .res_hit(res_hit), .res_idx(res_idx), .res_act(res_act)
);

// File: tb/seg_cam_test.sv
module seg_cam_test;

    localparam int ENTRIES = 8;
    localparam int KEY_W   = 144;
    localparam int SEG_W   = 36;
    localparam int NSEG    = KEY_W / SEG_W;
    localparam int IDXW    = 3;
    localparam int CW      = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               search_valid = 1'b0;
    logic [KEY_W-1:0]   search_key = '0;
    logic               search_ready;
    logic               wr_valid = 1'b0;
    logic [IDXW-1:0]    wr_idx = '0;
    logic [KEY_W-1:0]   wr_data = '0;
    logic               wr_ready;
    logic               res_valid;
    logic [ENTRIES-1:0] res_match;
    logic               res_hit;
    logic [IDXW-1:0]    res_idx;
    logic [NSEG*CW-1:0] res_act;

    seg_cam #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .SEG_W(SEG_W)) uut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int accepted = 0;
    int delivered = 0;
    logic prev_wr_ready = 1'b0;
    logic [IDXW-1:0] last_idx = '0;
    logic last_hit = 1'b0;

    // behavioural reference table and pending results
    logic [KEY_W-1:0]   m_mem [ENTRIES];
    logic               m_val [ENTRIES];
    int                 q_due [$];
    logic [ENTRIES-1:0] q_match [$];
    logic [IDXW-1:0]    q_idx [$];
    logic               q_hit [$];
    logic [NSEG*CW-1:0] q_act [$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [KEY_W-1:0] mk(input logic [35:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [KEY_W-1:0] act,
                       input logic [KEY_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic predict(input logic [KEY_W-1:0] key);
        logic [ENTRIES-1:0] mv;
        logic [NSEG*CW-1:0] av;
        logic [IDXW-1:0]    ix;
        mv = '0; av = '0; ix = '0;
        for (int s = 0; s < NSEG; s++) begin
            int n;
            n = 0;
            for (int e = 0; e < ENTRIES; e++) begin
                bit alive;
                alive = m_val[e];
                for (int p = 0; p < s; p++)
                    if (m_mem[e][p*SEG_W +: SEG_W] != key[p*SEG_W +: SEG_W]) alive = 0;
                if (alive) n++;
            end
            av[s*CW +: CW] = CW'(n);
        end
        for (int e = ENTRIES - 1; e >= 0; e--)
            if (m_val[e] && m_mem[e] == key) begin mv[e] = 1'b1; ix = IDXW'(e); end
        q_due.push_back(cyc + NSEG);
        q_match.push_back(mv);
        q_idx.push_back(ix);
        q_hit.push_back(mv != '0);
        q_act.push_back(av);
    endtask

    // cycle-by-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                chk(res_valid == 1'b1, "R8 result timing", KEY_W'(res_valid), 1);
                chk(res_match == q_match[0], "R2 match vector", KEY_W'(res_match), KEY_W'(q_match[0]));
                chk(res_hit == q_hit[0], "R3 hit flag", KEY_W'(res_hit), KEY_W'(q_hit[0]));
                chk(res_idx == q_idx[0], "R3 lowest index", KEY_W'(res_idx), KEY_W'(q_idx[0]));
                chk(res_act == q_act[0], "R4 stage activity", KEY_W'(res_act), KEY_W'(q_act[0]));
                last_idx = res_idx;
                last_hit = res_hit;
                delivered++;
                void'(q_due.pop_front()); void'(q_match.pop_front());
                void'(q_idx.pop_front()); void'(q_hit.pop_front()); void'(q_act.pop_front());
            end else begin
                chk(res_valid == 1'b0 && res_match == '0, "R8 idle output",
                    KEY_W'({res_valid, res_match}), 0);
            end
            if (wr_ready) begin
                chk(q_due.size() == 0, "R7 write before drain", KEY_W'(q_due.size()), 0);
                chk(!prev_wr_ready, "R6 ack pulse", 1, 0);
                m_mem[wr_idx] = wr_data;
                m_val[wr_idx] = 1'b1;
            end
            if (wr_valid)
                chk(!search_ready, "R7 search blocked", KEY_W'(search_ready), 0);
            if (search_valid && search_ready) begin
                predict(search_key);
                accepted++;
            end
            prev_wr_ready = wr_ready;
        end
    end

    task automatic srch(input logic [KEY_W-1:0] key);
        @(posedge clk); #2;
        search_valid = 1'b1;
        search_key   = key;
        @(negedge clk);
        while (!search_ready) @(negedge clk);
    endtask

    task automatic idle(input int n);
        @(posedge clk); #2;
        search_valid = 1'b0;
        repeat (n - 1) @(posedge clk);
    endtask

    // R6: request held until the one-cycle acknowledge
    task automatic wr(input logic [IDXW-1:0] idx, input logic [KEY_W-1:0] d);
        @(posedge clk); #2;
        search_valid = 1'b0;
        wr_valid = 1'b1;
        wr_idx   = idx;
        wr_data  = d;
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        @(posedge clk); #2;
        wr_valid = 1'b0;
    endtask

    initial begin
        for (int e = 0; e < ENTRIES; e++) begin m_mem[e] = '0; m_val[e] = 1'b0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(res_valid == 1'b0 && res_hit == 1'b0, "R1 reset outputs", KEY_W'({res_valid, res_hit}), 0);
        chk(search_ready == 1'b1 && wr_ready == 1'b0, "R1 reset handshake",
            KEY_W'({search_ready, wr_ready}), KEY_W'(2'b10));
        // R1/R9: zero key against empty table (storage holds zeros)
        srch('0);
        idle(NSEG + 2);
        chk(last_hit == 1'b0, "R9 invalid entries never match", KEY_W'(last_hit), 0);

        wr(0, mk(1, 2, 3, 4));
        wr(1, mk(1, 2, 3, 5));
        wr(2, mk(1, 9, 9, 9));
        wr(3, mk(7, 2, 3, 4));
        wr(4, mk(1, 2, 3, 4));

        // R5: back-to-back keys with differing survivor patterns
        srch(mk(1, 2, 3, 4));
        srch(mk(1, 2, 3, 5));
        srch(mk(1, 9, 9, 9));
        srch(mk(1, 2, 8, 8));
        srch('0);
        srch(mk(7, 2, 3, 4));
        srch(mk(5, 5, 5, 5));
        // R7/R10: overwrite while keys are in flight
        srch(mk(1, 2, 3, 4));
        srch(mk(1, 2, 3, 6));
        wr(0, mk(1, 2, 3, 6));
        srch(mk(1, 2, 3, 4));
        idle(NSEG + 2);
        chk(last_idx == 3'd4 && last_hit, "R10 overwritten entry no longer matches",
            KEY_W'(last_idx), 4);
        srch(mk(1, 2, 3, 6));
        srch(mk(1, 2, 3, 6));
        idle(2);
        srch(mk(1, 2, 9, 4));
        idle(NSEG + 3);
        chk(last_idx == 3'd0 && !last_hit, "R3 no hit gives index 0", KEY_W'(last_idx), 0);
        chk(delivered == accepted && q_due.size() == 0, "R5 one result per key",
            KEY_W'(delivered), KEY_W'(accepted));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule